// File: doc/BRIEF.md
# Paged Monochrome Run Writer

This block keeps an on-chip shadow copy of a 96 x 64 one-bit-per-pixel panel and keeps the panel controller's display memory in step with it. The shadow copy is stored in page format. Each byte holds eight vertically stacked pixels of one column, and the 64 rows form 8 pages of 8 rows.

A client starts a write by giving a row, a start column and a pixel count. It then streams the pixels packed horizontally into bytes. The block clips the run at the right edge of the panel. It merges every pixel into its shadow byte with a read-modify-write that leaves the other seven rows of that byte unchanged. It then emits a byte stream for a downstream serial shifter. That stream starts with three command bytes that set the page and the device column. The device column is the logical column plus a fixed offset of 18, because the controller addresses 132 segments. The updated shadow bytes of the run follow as data.

A read request returns a run of pixels taken only from the shadow copy, repacked horizontally. The controller itself cannot be read back.

Top module: `pagefb_run_writer`

## Requirements
- R1: After reset, `busy`, `out_valid`, `out_cs` and `rd_valid` are low, and every shadow pixel reads back as 0.
- R2: A request is taken only when `req_valid` is high and `busy` is low. A request presented while `busy` is high is ignored and produces no output of any kind.
- R3: The run length is clipped to min(`req_len`, 96 - `req_col`), and to 0 when `req_col` >= 96. A request with a clipped length of 0 starts no burst and no readback, leaves `busy` low, and leaves the shadow copy unchanged.
- R4: A write burst begins with three bytes that have `out_cmd` = 1, in this order: 0xB0 | page, 0x00 | (devcol & 0xF), 0x10 | (devcol >> 4). Here page = row / 8 and devcol = col + 18.
- R5: After the header come exactly as many bytes as the clipped length, each with `out_cmd` = 0. Byte i is the shadow byte of column col + i in the row's page, with bit (row % 8) set for a 1 pixel and cleared for a 0 pixel, and its other bits unchanged. The shadow copy keeps that value.
- R6: Write pixels are packed LSB first by default: pixel i is bit (i % 8) of input byte i / 8. Exactly ceil(clipped length / 8) input bytes are taken over the `pix_valid`/`pix_ready` handshake.
- R7: `out_cs` is high from the first header byte until the last data byte of the burst has been accepted, and low at all other times. `out_valid` is never high while `out_cs` is low.
- R8: A readback emits exactly ceil(clipped length / 8) bytes. Pixel i of the run goes to bit (i % 8) of byte i / 8. Bits past the end of the run are 0, and `rd_last` marks the final byte.
- R9: While `out_valid` is high and `out_ready` is low, `out_byte` and `out_cmd` hold their values until the byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_read | input | 1 | 1 = readback, 0 = write run |
| req_row | input | 6 | Pixel row 0..63 |
| req_col | input | 7 | Start column |
| req_len | input | 7 | Requested pixel count |
| busy | output | 1 | Burst or readback in progress |
| pix_valid | input | 1 | Packed pixel byte available |
| pix_data | input | 8 | Packed pixel byte |
| pix_ready | output | 1 | Block takes the pixel byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream shifter accepts the byte |
| out_byte | output | 8 | Command or data byte |
| out_cmd | output | 1 | 1 = command byte, 0 = data byte |
| out_cs | output | 1 | Panel select for the whole burst |
| rd_valid | output | 1 | Readback byte valid (one-cycle pulse) |
| rd_byte | output | 8 | Readback packed pixels |
| rd_last | output | 1 | Final byte of the readback |

## Verification
The hardest case to reach is a read-modify-write that must keep the bits of neighbouring rows in the same page. A single write cannot show whether those bits were kept. The stimulus therefore writes many random runs onto overlapping columns of shared pages, and then reads back every row of the panel against a model of the shadow copy. Back-pressure is produced by a random `out_ready` and random gaps in `pix_valid`. A read request injected in the middle of a write burst exercises the rule that requests arriving while `busy` is high are ignored.

// File: rtl/pfb_pkg.sv
// Shared types and opcode bases for the paged run writer.
package pfb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR_PAGE,
        ST_HDR_CLO,
        ST_HDR_CHI,
        ST_WDATA,
        ST_RDATA
    } pfb_state_e;

    localparam logic [7:0] OPC_PAGE   = 8'hB0;
    localparam logic [7:0] OPC_COL_LO = 8'h00;
    localparam logic [7:0] OPC_COL_HI = 8'h10;
endpackage

// File: rtl/pfb_shadow_mem.sv
// Shadow framebuffer: one byte per (page, column).
// Asynchronous read and synchronous write, cleared by reset.
// Assumes the address is in range whenever a write takes place.
module pfb_shadow_mem #(
    parameter int DEPTH = 768,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Storage update: clear on reset, otherwise write one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

    // R5: a merge changes at most the one row bit of the stored byte
    a_r5_single_bit_merge: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> $countones(wdata ^ rdata) <= 1);

    // R5: writes never leave the shadow array
    a_r5_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(addr) < DEPTH));
endmodule

// File: rtl/pfb_ctrl.sv
// Control for the paged run writer. It clips a requested run,
// sequences the three address command bytes, merges unpacked pixels
// into shadow bytes and streams them, or repacks shadow pixels for
// readback. Assumes an asynchronous-read shadow memory.
module pfb_ctrl
    import pfb_pkg::*;
#(
    parameter int COLS      = 96,
    parameter int ROWS      = 64,
    parameter int COL_OFS   = 18,
    parameter bit MSB_FIRST = 1'b0,
    parameter int ROW_W     = 6,
    parameter int COL_W     = 7,
    parameter int LEN_W     = 7,
    parameter int AW        = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_read,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [LEN_W-1:0] req_len,
    output logic             busy,
    input  logic             pix_valid,
    input  logic [7:0]       pix_data,
    output logic             pix_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_byte,
    output logic             out_cmd,
    output logic             out_cs,
    output logic             rd_valid,
    output logic [7:0]       rd_byte,
    output logic             rd_last,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [7:0]       mem_wdata,
    input  logic [7:0]       mem_rdata
);
    localparam int PG_W = ROW_W - 3;

    pfb_state_e       state;
    logic [PG_W-1:0]  page_q;
    logic [2:0]       rbit_q;
    logic [COL_W-1:0] col_q;
    logic [LEN_W-1:0] remain_q;
    logic [2:0]       bidx_q;
    logic [7:0]       pbuf_q;
    logic             pbuf_vld;
    logic [7:0]       racc_q;

    logic [LEN_W-1:0] avail, clen;
    logic             accept;
    logic [7:0]       devcol, rmask, merged, acc_next;
    logic [2:0]       slot;
    logic             pix_bit;

    // Clip the run at the right edge of the panel.
    always_comb begin
        avail  = (int'(req_col) >= COLS) ? '0 : LEN_W'(COLS - int'(req_col));
        clen   = (req_len > avail) ? avail : req_len;
        accept = req_valid && (state == ST_IDLE) && (clen != '0);
    end

    // Bit-order variant: the slot of pixel bidx within a packed byte.
    generate
        if (MSB_FIRST) begin : g_msb
            assign slot = ~bidx_q;
        end else begin : g_lsb
            assign slot = bidx_q;
        end
    endgenerate

    // Datapath: address, row merge, readback packing and header bytes.
    always_comb begin
        mem_addr  = AW'(page_q) * AW'(COLS) + AW'(col_q);
        devcol    = 8'(col_q) + 8'(COL_OFS);
        rmask     = 8'h01 << rbit_q;
        pix_bit   = pbuf_q[slot];
        merged    = pix_bit ? (mem_rdata | rmask) : (mem_rdata & ~rmask);
        acc_next  = ((bidx_q == 3'd0) ? 8'h00 : racc_q)
                    | (8'(mem_rdata[rbit_q]) << slot);
        mem_wdata = merged;
        mem_we    = (state == ST_WDATA) && pbuf_vld && out_ready;
        busy      = (state != ST_IDLE);
        pix_ready = (state == ST_WDATA) && !pbuf_vld;
        out_cmd   = (state == ST_HDR_PAGE) || (state == ST_HDR_CLO) || (state == ST_HDR_CHI);
        out_cs    = out_cmd || (state == ST_WDATA);
        out_valid = out_cmd || ((state == ST_WDATA) && pbuf_vld);
        case (state)
            ST_HDR_PAGE: out_byte = OPC_PAGE   | 8'(page_q);
            ST_HDR_CLO:  out_byte = OPC_COL_LO | {4'h0, devcol[3:0]};
            ST_HDR_CHI:  out_byte = OPC_COL_HI | {4'h0, devcol[7:4]};
            default:     out_byte = merged;
        endcase
    end

    // Sequencer: capture requests, step the header, data and readback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            page_q   <= '0;
            rbit_q   <= '0;
            col_q    <= '0;
            remain_q <= '0;
            bidx_q   <= '0;
            pbuf_q   <= '0;
            pbuf_vld <= 1'b0;
            racc_q   <= '0;
            rd_valid <= 1'b0;
            rd_byte  <= '0;
            rd_last  <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        page_q   <= req_row[ROW_W-1:3];
                        rbit_q   <= req_row[2:0];
                        col_q    <= req_col;
                        remain_q <= clen;
                        bidx_q   <= '0;
                        pbuf_vld <= 1'b0;
                        racc_q   <= '0;
                        state    <= req_read ? ST_RDATA : ST_HDR_PAGE;
                    end
                end
                ST_HDR_PAGE: if (out_ready) state <= ST_HDR_CLO;
                ST_HDR_CLO:  if (out_ready) state <= ST_HDR_CHI;
                ST_HDR_CHI:  if (out_ready) state <= ST_WDATA;
                ST_WDATA: begin
                    if (!pbuf_vld) begin
                        if (pix_valid) begin
                            pbuf_q   <= pix_data;
                            pbuf_vld <= 1'b1;
                        end
                    end else if (out_ready) begin
                        col_q    <= col_q + 1'b1;
                        bidx_q   <= bidx_q + 1'b1;
                        remain_q <= remain_q - 1'b1;
                        if (bidx_q == 3'd7 || remain_q == LEN_W'(1)) pbuf_vld <= 1'b0;
                        if (remain_q == LEN_W'(1)) state <= ST_IDLE;
                    end
                end
                ST_RDATA: begin
                    racc_q   <= acc_next;
                    bidx_q   <= bidx_q + 1'b1;
                    col_q    <= col_q + 1'b1;
                    remain_q <= remain_q - 1'b1;
                    if (bidx_q == 3'd7 || remain_q == LEN_W'(1)) begin
                        rd_valid <= 1'b1;
                        rd_byte  <= acc_next;
                        rd_last  <= (remain_q == LEN_W'(1));
                    end
                    if (remain_q == LEN_W'(1)) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: a stalled output byte holds steady
    a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_cmd)));

    // R7: no byte is offered outside a selected burst
    a_r7_valid_in_select: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_cs);

    // R4: once data has started, no command byte follows within the burst
    a_r4_no_cmd_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_cmd) |=> !(out_valid && out_cmd));

    // R8: nothing follows the final readback byte
    a_r8_nothing_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_last) |=> !rd_valid);
endmodule

// File: rtl/pagefb_run_writer.sv
// Paged monochrome run writer top level. It joins the control
// sequencer to the shadow framebuffer. Assumes one panel and a
// downstream shifter that takes bytes over a valid/ready handshake.
module pagefb_run_writer #(
    parameter int  COLS      = 96,
    parameter int  ROWS      = 64,
    parameter int  COL_OFS   = 18,
    parameter bit  MSB_FIRST = 1'b0,
    localparam int ROW_W     = $clog2(ROWS),
    localparam int COL_W     = $clog2(COLS + 1),
    localparam int LEN_W     = $clog2(COLS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_read,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [LEN_W-1:0] req_len,
    output logic             busy,
    input  logic             pix_valid,
    input  logic [7:0]       pix_data,
    output logic             pix_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_byte,
    output logic             out_cmd,
    output logic             out_cs,
    output logic             rd_valid,
    output logic [7:0]       rd_byte,
    output logic             rd_last
);
    localparam int DEPTH = COLS * (ROWS / 8);
    localparam int AW    = $clog2(DEPTH);

    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, mem_rdata;

    pfb_ctrl #(
        .COLS(COLS), .ROWS(ROWS), .COL_OFS(COL_OFS), .MSB_FIRST(MSB_FIRST),
        .ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W), .AW(AW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_read(req_read),
        .req_row(req_row), .req_col(req_col), .req_len(req_len),
        .busy(busy),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
        .out_cmd(out_cmd), .out_cs(out_cs),
        .rd_valid(rd_valid), .rd_byte(rd_byte), .rd_last(rd_last),
        .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    pfb_shadow_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(mem_addr),
        .wdata(mem_wdata), .rdata(mem_rdata)
    );
endmodule

// File: tb/test_pagefb_run_writer.sv
// Self-checking bench: directed corners plus seeded random runs,
// compared against a model of the shadow copy kept in the bench.
module test_pagefb_run_writer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_read = 1'b0;
    logic [5:0] req_row = '0;
    logic [6:0] req_col = '0, req_len = '0;
    logic busy, pix_ready, out_valid, out_cmd, out_cs, rd_valid, rd_last;
    logic pix_valid = 1'b0, out_ready = 1'b0;
    logic [7:0] pix_data = '0;
    logic [7:0] out_byte, rd_byte;

    int vectors = 0, fails = 0, cyc = 0;
    logic [7:0] mdl [768];
    logic [7:0] stim [16];
    logic [7:0] expb [128];

    always #5 clk = ~clk;

    pagefb_run_writer i_pagefb_run_writer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_row(req_row), .req_col(req_col), .req_len(req_len), .busy(busy),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
        .out_cmd(out_cmd), .out_cs(out_cs), .rd_valid(rd_valid),
        .rd_byte(rd_byte), .rd_last(rd_last)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    function automatic int clip(input int col, input int len);
        if (col >= 96) return 0;
        return (len > 96 - col) ? 96 - col : len;
    endfunction

    task automatic do_write(input int row, input int col, input int len);
        int clen, nb, nrec, pidx, t, rdseen, dc;
        clen = clip(col, len);
        nb = (clen + 7) / 8;
        for (int i = 0; i < 16; i++) stim[i] = 8'($urandom);
        @(negedge clk);
        req_row = 6'(row); req_col = 7'(col); req_len = 7'(len);
        req_read = 1'b0; req_valid = 1'b1;
        if (clen == 0) begin
            @(negedge clk); req_valid = 1'b0;
            t = 0;
            for (int k = 0; k < 5; k++) begin
                if (busy || out_valid || out_cs || pix_ready) t++;
                @(negedge clk);
            end
            check(t == 0, "R3 empty run starts no burst", t, 0);
            return;
        end
        // Expected header and merged data (R4, R5, R6)
        dc = col + 18;
        expb[0] = 8'hB0 | 8'(row / 8);
        expb[1] = 8'h00 | 8'(dc % 16);
        expb[2] = 8'h10 | 8'(dc / 16);
        for (int i = 0; i < clen; i++) begin
            int a;
            a = (row / 8) * 96 + col + i;
            if (stim[i / 8][i % 8]) mdl[a] = mdl[a] | (8'h01 << (row % 8));
            else                    mdl[a] = mdl[a] & ~(8'h01 << (row % 8));
            expb[3 + i] = mdl[a];
        end
        @(negedge clk);
        nrec = 0; pidx = 0; t = 0; rdseen = 0;
        while (nrec < 3 + clen && t < 3000) begin
            out_ready = ($urandom % 4) != 0;
            pix_valid = (pidx < nb) && (($urandom % 3) != 0);
            pix_data  = (pidx < nb) ? stim[pidx] : 8'h00;
            req_valid = (t == 4);
            req_read  = 1'b1;
            #1;
            if (rd_valid) rdseen++;
            if (pix_valid && pix_ready) pidx++;
            if (out_valid && out_ready) begin
                check(out_byte == expb[nrec] && out_cmd == (nrec < 3) && out_cs,
                      (nrec < 3) ? "R4 header byte" : "R5 data byte",
                      {out_cs, out_cmd, out_byte}, {1'b1, nrec < 3, expb[nrec]});
                nrec++;
            end
            @(negedge clk);
            t++;
        end
        req_valid = 1'b0; out_ready = 1'b0; pix_valid = 1'b0;
        check(nrec == 3 + clen, "R5 byte count", nrec, 3 + clen);
        #1;
        check(!out_cs && !busy, "R7 select released after burst", {out_cs, busy}, 0);
        check(pidx == nb, "R6 input bytes consumed", pidx, nb);
        for (int k = 0; k < 3; k++) begin
            if (rd_valid) rdseen++;
            @(negedge clk);
        end
        check(rdseen == 0, "R2 request while busy ignored", rdseen, 0);
    endtask

    task automatic do_read(input int row, input int col, input int len);
        int clen, nb, cnt;
        logic [7:0] eb [12];
        clen = clip(col, len);
        nb = (clen + 7) / 8;
        for (int i = 0; i < 12; i++) eb[i] = 8'h00;
        for (int i = 0; i < clen; i++)
            if (mdl[(row / 8) * 96 + col + i][row % 8]) eb[i / 8][i % 8] = 1'b1;
        @(negedge clk);
        req_row = 6'(row); req_col = 7'(col); req_len = 7'(len);
        req_read = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cnt = 0;
        for (int k = 0; k < clen + 6; k++) begin
            if (rd_valid) begin
                if (cnt < nb)
                    check(rd_byte == eb[cnt] && rd_last == (cnt == nb - 1),
                          "R8 readback byte", {rd_last, rd_byte}, {cnt == nb - 1, eb[cnt]});
                cnt++;
            end
            @(negedge clk);
        end
        check(cnt == nb, "R8 readback byte count", cnt, nb);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 768; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        #1;
        check(!busy && !out_valid && !out_cs && !rd_valid, "R1 reset outputs",
              {busy, out_valid, out_cs, rd_valid}, 0);
        rst_n = 1'b1;
        do_read(0, 0, 96);     // R1 cleared shadow
        do_read(63, 0, 96);    // R1 cleared shadow, last row
        do_write(0, 0, 96);    // full row
        do_write(63, 95, 1);   // bottom-right corner pixel
        do_write(45, 90, 20);  // R3 clipped to 6
        do_write(10, 96, 5);   // R3 start past edge
        do_write(10, 5, 0);    // R3 zero length
        do_write(1, 0, 96);    // R5 same page, neighbouring row
        do_read(0, 0, 96);
        do_read(1, 3, 13);     // R8 partial final byte
        do_read(45, 88, 30);   // R3 clipped readback
        do_read(20, 100, 4);   // R3 empty readback
        for (int n = 0; n < 80; n++) begin
            int r, c, l;
            r = $urandom % 64;
            c = ($urandom % 8 == 0) ? 90 + $urandom % 20 : $urandom % 96;
            l = $urandom % 100;
            if ($urandom % 3 == 0) do_read(r, c, l);
            else do_write(r, c, l);
        end
        for (int r = 0; r < 64; r++) do_read(r, 0, 96);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule